// File: doc/BRIEF.md
# Handshaked DMA Transfer Controller

This block moves 8-bit words between a memory and an I/O device over one shared 8-bit bidirectional transfer bus. It runs on the processor clock. Both peripherals sit in other clock domains, so every exchange with them is a valid/return handshake, and the return line passes through a synchronizer before the state machine uses it. The processor pulses a start input and then supplies a five-bit configuration word on each of four cycles. These four words give the transfer mode (one word or a four-word burst), the direction, and the source and destination addresses.

Once configured, the controller requests the bus and waits for the grant. For each word it does three things in order. It presents the source address and collects the data the source returns. It then presents the destination address. Finally it presents the data. Valid always rises one cycle after the bus value is set up. A single rising edge of the return input advances each waiting step. On the read step that same edge acknowledges the source address and also marks the data as ready. Each waiting step is watched by a timeout. If it expires, the controller aborts to idle with request and done both low. A clean finish leaves done high until the next start.

Top module: `dma_xfer_ctrl`

## Requirements
- R1: While reset is applied, and after it is released, `req_o`, `done_o`, `valid_o`, `ack_o` and `bus_oe_o` are low.
- R2: A high `start_i` in idle begins preparation. The next four cycles capture `cfg_i` in this order. First: burst flag in bit 0, direction in bit 1, source bits 7:5 in bits 4:2. Second: source bits 4:0. Third: destination bits 7:5 in bits 4:2. Fourth: destination bits 4:0.
- R3: After preparation `req_o` goes high. The bus stays undriven and valid stays low until `grant_i` is seen high.
- R4: In the source step, `bus_o` carries the source address with `bus_oe_o` high and `wr_en_o` low. `tgt_o` equals the direction bit (target 0 is memory, 1 is I/O; direction 0 means memory to I/O). `valid_o` is low in the first cycle and high in the second.
- R5: In the receive step the bus is released (`bus_oe_o` low) and `valid_o` stays high. A return rise captures `bus_i` and raises `ack_o`, which stays high for the whole destination-address step.
- R6: The destination-address step and then the data step each drive the bus (destination address, then captured data) with `wr_en_o` high and `tgt_o` equal to the inverse of the direction bit. Valid is low in the first cycle of each step and high after it.
- R7: `ret_i` is synchronized through two flops. Only a rising edge advances a step, so a return held high does not advance more than one step.
- R8: In burst mode four words are moved, and source and destination addresses both increase by 1 (modulo 256) after each word.
- R9: After the last data handshake the controller returns to idle with `req_o` low and `done_o` high. `done_o` holds until the next start.
- R10: If no return rise is accepted within `TMO_CYC` cycles of entering the receive, destination-address or data step, the controller returns to idle with `req_o`, `done_o` and `ack_o` low.
- R11: Accepting a new start clears `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin loading a transfer configuration |
| grant_i | input | 1 | Bus grant from the processor |
| ret_i | input | 1 | Return strobe from the addressed peripheral (asynchronous) |
| cfg_i | input | 5 | Configuration slice, one per preparation cycle |
| bus_i | input | 8 | Transfer bus value seen from the pads |
| req_o | output | 1 | Bus request to the processor |
| wr_en_o | output | 1 | High when writing to the destination |
| done_o | output | 1 | Transfer completed successfully |
| valid_o | output | 1 | Bus value or outstanding request is valid |
| ack_o | output | 1 | Data from the source has been captured |
| tgt_o | output | 1 | Addressed side: 0 memory, 1 I/O |
| bus_o | output | 8 | Value driven onto the transfer bus |
| bus_oe_o | output | 1 | Output enable for the transfer bus pads |

## Verification
The bench targets the burst address step across the 8-bit wrap (source 0xFE, destination 0xFF). A design that carried into a wider field, or that bumped the address before the first word, would present the wrong address. It holds the return line high through the destination step. A level-sensitive design would jump straight to the data step and put the data where the address belongs. It also withholds the return entirely so the timeout must fire, and it checks that done stays low and the bus is released afterwards. Finally it stalls the grant to confirm that nothing is driven early, and checks the one-cycle gap between bus setup and valid on every step. A design that raised valid together with the data would fail that gap check.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
  localparam int unsigned DMX_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREP,
    ST_WAITG,
    ST_SRC,
    ST_RECV,
    ST_DADDR,
    ST_DDATA
  } dmx_state_e;

  typedef struct packed {
    logic             burst;
    logic             dir;
    logic [DMX_W-1:0] src;
    logic [DMX_W-1:0] dst;
  } dmx_cfg_t;
endpackage

// File: rtl/dmx_ret_sync.sv
module dmx_ret_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ret_i,
  output logic rise_o
);
  // sh[STAGES-1] is the synchronized level, sh[STAGES] its delayed copy
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], ret_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

  // R7: the rise pulse is exactly one cycle wide
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/dmx_cfg_load.sv
module dmx_cfg_load
  import dmx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cap_en,
  input  logic [1:0] idx,
  input  logic [4:0] cfg_i,
  input  logic     step,
  output dmx_cfg_t cfg_o
);
  dmx_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (cap_en) begin
      unique case (idx)
        2'd0: begin
          cfg_d.burst    = cfg_i[0];
          cfg_d.dir      = cfg_i[1];
          cfg_d.src[7:5] = cfg_i[4:2];
        end
        2'd1: cfg_d.src[4:0] = cfg_i;
        2'd2: cfg_d.dst[7:5] = cfg_i[4:2];
        default: cfg_d.dst[4:0] = cfg_i;
      endcase
    end else if (step) begin
      cfg_d.src = cfg_q.src + DMX_W'(1);
      cfg_d.dst = cfg_q.dst + DMX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cfg_q <= '0;
    else if (cap_en || step)  cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;

  // R8: an address step moves both addresses by exactly one
  a_r8_step_both: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !cap_en) |=> (cfg_o.src == $past(cfg_o.src) + 8'd1) &&
                          (cfg_o.dst == $past(cfg_o.dst) + 8'd1));
endmodule

// File: rtl/dmx_wdog.sv
module dmx_wdog #(
  parameter int unsigned LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic hit_o
);
  localparam int unsigned CW = $clog2(LIMIT) + 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (clr)                  cnt_q <= '0;
    else if (run && cnt_q != LAST) cnt_q <= cnt_q + CW'(1);
  end

  assign hit_o = run && (cnt_q == LAST);
endmodule

// File: rtl/dma_xfer_ctrl.sv
module dma_xfer_ctrl
  import dmx_pkg::*;
#(
  parameter int unsigned TMO_CYC     = 64,
  parameter int unsigned BURST_LEN   = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       grant_i,
  input  logic       ret_i,
  input  logic [4:0] cfg_i,
  input  logic [7:0] bus_i,
  output logic       req_o,
  output logic       wr_en_o,
  output logic       done_o,
  output logic       valid_o,
  output logic       ack_o,
  output logic       tgt_o,
  output logic [7:0] bus_o,
  output logic       bus_oe_o
);
  localparam int unsigned WCW = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam logic [WCW-1:0] WLAST = WCW'(BURST_LEN - 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  dmx_state_e       state_q, state_d;
  logic [1:0]       sub_q, sub_d;
  logic [WCW-1:0]   word_q, word_d;
  logic             ack_q, ack_d;
  logic             done_q, done_d;
  logic [DMX_W-1:0] data_q;
  logic             data_en, cap_en, step;
  logic             ret_rise, tmo_hit, waiting;
  dmx_cfg_t         cfg;

  dmx_ret_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sn), .ret_i(ret_i), .rise_o(ret_rise));

  dmx_cfg_load u_cfg (
    .clk(clk), .rst_n(rst_sn), .cap_en(cap_en), .idx(sub_q),
    .cfg_i(cfg_i), .step(step), .cfg_o(cfg));

  assign waiting = (state_q == ST_RECV) || (state_q == ST_DADDR) ||
                   (state_q == ST_DDATA);

  dmx_wdog #(.LIMIT(TMO_CYC)) u_wdog (
    .clk(clk), .rst_n(rst_sn), .clr(state_d != state_q),
    .run(waiting), .hit_o(tmo_hit));

  // next-state logic
  always_comb begin
    state_d = state_q;
    sub_d   = sub_q;
    word_d  = word_q;
    ack_d   = ack_q;
    done_d  = done_q;
    data_en = 1'b0;
    cap_en  = 1'b0;
    step    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_PREP;
          sub_d   = 2'd0;
          word_d  = '0;
          done_d  = 1'b0;
        end
      end
      ST_PREP: begin
        cap_en = 1'b1;
        if (sub_q == 2'd3) begin
          state_d = ST_WAITG;
          sub_d   = 2'd0;
        end else begin
          sub_d = sub_q + 2'd1;
        end
      end
      ST_WAITG: begin
        if (grant_i) begin
          state_d = ST_SRC;
          sub_d   = 2'd0;
        end
      end
      ST_SRC: begin
        if (sub_q == 2'd0) sub_d = 2'd1;
        else begin
          state_d = ST_RECV;
          sub_d   = 2'd0;
        end
      end
      ST_RECV: begin
        if (ret_rise) begin
          data_en = 1'b1;
          ack_d   = 1'b1;
          state_d = ST_DADDR;
          sub_d   = 2'd0;
        end else if (tmo_hit) begin
          state_d = ST_IDLE;
          done_d  = 1'b0;
        end
      end
      ST_DADDR: begin
        if (sub_q == 2'd0) sub_d = 2'd1;
        if (sub_q != 2'd0 && ret_rise) begin
          state_d = ST_DDATA;
          sub_d   = 2'd0;
          ack_d   = 1'b0;
        end else if (tmo_hit) begin
          state_d = ST_IDLE;
          ack_d   = 1'b0;
          done_d  = 1'b0;
        end
      end
      ST_DDATA: begin
        if (sub_q == 2'd0) sub_d = 2'd1;
        if (sub_q != 2'd0 && ret_rise) begin
          sub_d = 2'd0;
          if (cfg.burst && word_q != WLAST) begin
            state_d = ST_SRC;
            step    = 1'b1;
            word_d  = word_q + WCW'(1);
          end else begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end
        end else if (tmo_hit) begin
          state_d = ST_IDLE;
          done_d  = 1'b0;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= ST_IDLE;
      sub_q   <= '0;
      word_q  <= '0;
      ack_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sub_q   <= sub_d;
      word_q  <= word_d;
      ack_q   <= ack_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)      data_q <= '0;
    else if (data_en) data_q <= bus_i;
  end

  // outputs decoded from state
  logic drv_src, drv_dst, drv_dat;
  assign drv_src = (state_q == ST_SRC);
  assign drv_dst = (state_q == ST_DADDR);
  assign drv_dat = (state_q == ST_DDATA);

  assign req_o    = (state_q != ST_IDLE) && (state_q != ST_PREP);
  assign bus_oe_o = drv_src || drv_dst || drv_dat;
  assign wr_en_o  = drv_dst || drv_dat;
  assign valid_o  = (state_q == ST_RECV) || (bus_oe_o && sub_q != 2'd0);
  assign tgt_o    = (drv_src || state_q == ST_RECV) ? cfg.dir :
                    wr_en_o ? ~cfg.dir : 1'b0;
  assign bus_o    = drv_src ? cfg.src : drv_dst ? cfg.dst :
                    drv_dat ? data_q : '0;
  assign ack_o    = ack_q;
  assign done_o   = done_q;

  // R3: nothing driven or flagged valid without the bus request
  a_r3_no_drive_without_req: assert property (@(posedge clk) disable iff (!rst_sn)
    !req_o |-> (!bus_oe_o && !valid_o));
  // R4/R6: valid lags a freshly driven bus by one cycle
  a_r4_valid_lags_drive: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(bus_oe_o) |-> !valid_o);
  // R5: ack only rises after a return rise
  a_r5_ack_after_rise: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(ack_o) |-> $past(ret_rise));
  // R6: writes always drive the bus under a held request
  a_r6_write_drives: assert property (@(posedge clk) disable iff (!rst_sn)
    wr_en_o |-> (bus_oe_o && req_o));
  // R9: success releases the bus
  a_r9_done_releases: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(done_o) |-> (!req_o && !bus_oe_o));
  // R10: a drop of request without done follows a timeout
  a_r10_abort_on_timeout: assert property (@(posedge clk) disable iff (!rst_sn)
    ($fell(req_o) && !done_o) |-> $past(tmo_hit));
endmodule

// File: tb/dma_xfer_ctrl_tb.sv
`timescale 1ns/1ps
module dma_xfer_ctrl_tb;
  localparam int unsigned TMO = 24;

  logic       clk = 1'b0;
  logic       rst_n, start_i, grant_i, ret_i;
  logic [4:0] cfg_i;
  logic [7:0] bus_i;
  logic       req_o, wr_en_o, done_o, valid_o, ack_o, tgt_o, bus_oe_o;
  logic [7:0] bus_o;
  int errs = 0;
  int checks = 0;
  bit fin = 1'b0;

  always #2.5 clk = ~clk;

  dma_xfer_ctrl #(.TMO_CYC(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .grant_i(grant_i),
    .ret_i(ret_i), .cfg_i(cfg_i), .bus_i(bus_i), .req_o(req_o),
    .wr_en_o(wr_en_o), .done_o(done_o), .valid_o(valid_o), .ack_o(ack_o),
    .tgt_o(tgt_o), .bus_o(bus_o), .bus_oe_o(bus_oe_o));

  // {burst, dir, src, dst, data3, data2, data1, data0}
  localparam logic [49:0] VEC [4] = '{
    {1'b0, 1'b0, 8'hA5, 8'h3C, 32'h0000_005A},
    {1'b0, 1'b1, 8'h1F, 8'hE0, 32'h0000_00C3},
    {1'b1, 1'b0, 8'h10, 8'h80, 32'h4433_2211},
    {1'b1, 1'b1, 8'hFE, 8'hFF, 32'h817E_FF00}
  };

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // start, load config, hold off grant, then grant; returns at source step cycle 0
  task automatic setup(input logic burst, input logic dir, input logic [7:0] src,
                       input logic [7:0] dst);
    start_i = 1'b1; tick();
    start_i = 1'b0; cfg_i = {src[7:5], dir, burst}; tick();
    cfg_i = src[4:0]; tick();
    cfg_i = {dst[7:5], 2'b00}; tick();
    cfg_i = dst[4:0]; tick();
    cfg_i = '0;
    chk("R3 req after prep", {req_o, bus_oe_o, valid_o}, 3'b100);
    chk("R11 done cleared by start", done_o, 1'b0);
    tick(2);
    chk("R3 still waiting for grant", {req_o, bus_oe_o, valid_o}, 3'b100);
    grant_i = 1'b1; tick();
  endtask

  task automatic run_xfer(input logic [49:0] v);
    logic burst, dir;
    logic [7:0] src, dst, d;
    int nw;
    burst = v[49]; dir = v[48]; src = v[47:40]; dst = v[39:32];
    nw = burst ? 4 : 1;
    setup(burst, dir, src, dst);
    for (int k = 0; k < nw; k++) begin
      d = v[8*k +: 8];
      ret_i = 1'b0;
      chk("R2 R4 R8 source addr", {bus_oe_o, valid_o, wr_en_o, tgt_o, bus_o},
          {1'b1, 1'b0, 1'b0, dir, 8'(src + k)});
      tick();
      chk("R4 valid second cycle", {bus_oe_o, valid_o, bus_o}, {2'b11, 8'(src + k)});
      tick();
      chk("R5 receive releases bus", {bus_oe_o, valid_o, tgt_o}, {2'b01, dir});
      bus_i = d; ret_i = 1'b1; tick(3);
      chk("R5 ack after return", ack_o, 1'b1);
      chk("R2 R6 R8 dest addr", {bus_oe_o, valid_o, wr_en_o, tgt_o, bus_o},
          {1'b1, 1'b0, 1'b1, ~dir, 8'(dst + k)});
      ret_i = 1'b0; bus_i = 8'h00; tick();
      chk("R6 dest valid", {valid_o, ack_o}, 2'b11);
      tick(2); ret_i = 1'b1; tick(3);
      chk("R6 data step", {bus_oe_o, valid_o, wr_en_o, tgt_o, ack_o, bus_o},
          {1'b1, 1'b0, 1'b1, ~dir, 1'b0, d});
      ret_i = 1'b0; tick();
      chk("R6 data valid", valid_o, 1'b1);
      tick(2); ret_i = 1'b1; tick(3);
    end
    ret_i = 1'b0; grant_i = 1'b0;
    chk("R9 R8 done after words", {req_o, done_o, bus_oe_o, valid_o}, 4'b0100);
    tick(3);
    chk("R9 done holds", {req_o, done_o}, 2'b01);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; grant_i = 1'b0; ret_i = 1'b0;
    cfg_i = '0; bus_i = '0;
    tick(3);
    chk("R1 in reset", {req_o, done_o, valid_o, ack_o, bus_oe_o}, 5'b0);
    rst_n = 1'b1; tick(3);
    chk("R1 after reset", {req_o, done_o, valid_o, ack_o, bus_oe_o}, 5'b0);

    for (int i = 0; i < 4; i++) run_xfer(VEC[i]);

    // R10: source never returns
    setup(1'b0, 1'b0, 8'h44, 8'h55);
    tick(2);
    chk("R10 receive waiting", {req_o, valid_o}, 2'b11);
    tick(TMO - 4);
    chk("R10 before timeout", req_o, 1'b1);
    tick(8);
    chk("R10 abort", {req_o, done_o, bus_oe_o, valid_o, ack_o}, 5'b0);
    grant_i = 1'b0;

    // R7: return held high advances only one step
    setup(1'b0, 1'b1, 8'h21, 8'h9A);
    tick(2);
    bus_i = 8'h77; ret_i = 1'b1; tick(3);
    chk("R7 one step on rise", {ack_o, bus_o}, {1'b1, 8'h9A});
    tick(8);
    chk("R7 held level ignored", {bus_oe_o, wr_en_o, bus_o}, {2'b11, 8'h9A});
    tick(TMO + 2);
    chk("R10 R7 abort in dest step", {req_o, done_o, ack_o, bus_oe_o}, 4'b0);
    ret_i = 1'b0; grant_i = 1'b0; tick(3);

    // R11 and R1: mid-run reset after a clean transfer
    run_xfer(VEC[0]);
    rst_n = 1'b0; tick();
    chk("R1 reset clears done", {done_o, req_o}, 2'b00);
    rst_n = 1'b1; tick(3);

    fin = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      checks++; errs++;
      $display("FAIL watchdog (all) actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule